// File: doc/BRIEF.md
# Track Offset Control Sequencer

This block moves the head a small fixed distance off track center on command, and manages the completion flags while each move settles. The controller sends a tag strobe with two request bits. One bit asks for a plus offset, which moves the head outward. The other bit asks for a minus offset, which moves it inward. When neither bit is set, the offset is cleared. Requests are taken only while the drive is selected. The block drives three signals toward the servo: offset-active, the outward direction, and a fixed-offset enable. The analog offset injection is done elsewhere.

Each time offset-active turns on or off, a settle timer starts and both seek-end and on-cylinder drop. The timer length is a parameter counted in clock cycles. When the timer runs out after an offset is applied, both flags come back. When it runs out after an offset is removed, seek-end comes back, but on-cylinder comes back only if the head reports on-track at that moment. Any new change while the timer is running restarts the full window.

Top module: `ofs_seq_ctrl`

## Requirements
- R1: After reset, ofs_plus, ofs_minus, ofs_active, ofs_en and ofs_dir_out are low, and seek_end and on_cyl are high.
- R2: A strobe taken while selected, with req_plus=1, req_minus=0 and abn=0, makes ofs_plus, ofs_active, ofs_en and ofs_dir_out high on the next clock, with ofs_minus low.
- R3: A strobe taken while selected, with req_minus=1, req_plus=0 and abn=0, makes ofs_minus, ofs_active and ofs_en high and ofs_dir_out low on the next clock, with ofs_plus low.
- R4: If abn is high when a plus or minus request is taken, the request latch and direction still update, but ofs_active and ofs_en are low on the next clock.
- R5: A strobe while sel is low, or any cycle without a strobe, leaves every offset output unchanged.
- R6: A strobe with both request bits set is ignored, and the offset outputs keep their values.
- R7: The clock after ofs_active changes, seek_end and on_cyl are low. They stay low for exactly SETTLE_CYC cycles.
- R8: After a change that raises ofs_active, seek_end and on_cyl both return high when the settle window ends.
- R9: A strobe taken while selected with both request bits low drives ofs_plus, ofs_minus, ofs_active, ofs_en and ofs_dir_out low on the next clock.
- R10: After a change that lowers ofs_active, seek_end returns high when the window ends. on_cyl then takes the value of on_track sampled on that final clock.
- R11: A change of ofs_active during a running window restarts the full SETTLE_CYC window. The kind of the newest change decides how on_cyl is restored.
- R12: Switching directly between plus and minus while active does not change ofs_active, so it starts no settle window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sel | input | 1 | Drive selected |
| tag_stb | input | 1 | One-cycle request strobe |
| req_plus | input | 1 | Plus (outward) offset request bit |
| req_minus | input | 1 | Minus (inward) offset request bit |
| abn | input | 1 | Abnormal condition; blocks activation |
| on_track | input | 1 | Head is at track center |
| ofs_plus | output | 1 | Plus offset latched |
| ofs_minus | output | 1 | Minus offset latched |
| ofs_active | output | 1 | Offset in effect |
| ofs_en | output | 1 | Fixed-offset enable to the servo |
| ofs_dir_out | output | 1 | Direction, 1 = outward |
| seek_end | output | 1 | Seek-end flag |
| on_cyl | output | 1 | On-cylinder flag |

## Verification
The hardest case to reach is a restart of the settle window. The second change has to arrive while the first window is still running, and then the flags must be shown to hold low for a full window measured from the second change. The bench applies a plus offset, waits half a window, clears it with on_track low, and then samples the exact cycle before and after the restarted window ends. A clear while the offset is blocked by abn is also driven. It shows that no active edge occurs, so no window starts.

// File: rtl/ofs_seq_pkg.sv
package ofs_seq_pkg;

    typedef enum logic [1:0] {
        REQ_NONE  = 2'd0,
        REQ_PLUS  = 2'd1,
        REQ_MINUS = 2'd2,
        REQ_CLEAR = 2'd3
    } ofs_req_e;

    typedef enum logic {
        SETTLE_APPLY = 1'b0,
        SETTLE_CLEAR = 1'b1
    } settle_kind_e;

    typedef struct packed {
        logic plus;
        logic minus;
        logic active;
        logic dir_out;
    } ofs_state_t;

    localparam ofs_state_t OFS_IDLE = '{plus: 1'b0, minus: 1'b0, active: 1'b0, dir_out: 1'b0};

    // Classify a strobe; conflicting bits are treated as no request.
    function automatic ofs_req_e classify_req(input logic stb, input logic sel,
                                              input logic bp, input logic bm);
        ofs_req_e r;
        r = REQ_NONE;
        if (stb && sel) begin
            unique case ({bp, bm})
                2'b10:   r = REQ_PLUS;
                2'b01:   r = REQ_MINUS;
                2'b00:   r = REQ_CLEAR;
                default: r = REQ_NONE;
            endcase
        end
        return r;
    endfunction

    function automatic ofs_state_t step_state(input ofs_state_t cur, input ofs_req_e req,
                                              input logic blocked);
        ofs_state_t n;
        n = cur;
        unique case (req)
            REQ_PLUS:  n = '{plus: 1'b1, minus: 1'b0, active: ~blocked, dir_out: 1'b1};
            REQ_MINUS: n = '{plus: 1'b0, minus: 1'b1, active: ~blocked, dir_out: 1'b0};
            REQ_CLEAR: n = OFS_IDLE;
            default:   n = cur;
        endcase
        return n;
    endfunction

endpackage

// File: rtl/ofs_req_decode.sv
module ofs_req_decode
    import ofs_seq_pkg::*;
(
    input  logic     sel,
    input  logic     tag_stb,
    input  logic     req_plus,
    input  logic     req_minus,
    output ofs_req_e req
);
    always_comb begin
        req = classify_req(tag_stb, sel, req_plus, req_minus);
    end
endmodule

// File: rtl/ofs_state_reg.sv
module ofs_state_reg
    import ofs_seq_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  ofs_req_e   req,
    input  logic       abn,
    output ofs_state_t st
);
    always_ff @(posedge clk) begin
        if (rst) st <= OFS_IDLE;
        else     st <= step_state(st, req, abn);
    end
endmodule

// File: rtl/ofs_edge_detect.sv
module ofs_edge_detect
    import ofs_seq_pkg::*;
(
    input  logic         clk,
    input  logic         rst,
    input  logic         active,
    output logic         pulse,
    output settle_kind_e kind
);
    logic active_q;

    always_ff @(posedge clk) begin
        if (rst) active_q <= 1'b0;
        else     active_q <= active;
    end

    always_comb begin
        pulse = active ^ active_q;
        kind  = active ? SETTLE_APPLY : SETTLE_CLEAR;
    end
endmodule

// File: rtl/ofs_settle_timer.sv
module ofs_settle_timer
    import ofs_seq_pkg::*;
#(
    parameter int unsigned SETTLE_CYC = 625000
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         start,
    input  settle_kind_e kind,
    input  logic         on_track,
    output logic         seek_end,
    output logic         on_cyl
);
    localparam int unsigned CNT_W = (SETTLE_CYC > 1) ? $clog2(SETTLE_CYC) : 1;
    localparam logic [CNT_W-1:0] LOAD_VAL = CNT_W'(SETTLE_CYC - 1);

    logic             busy;
    logic [CNT_W-1:0] cnt;
    settle_kind_e     kind_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy     <= 1'b0;
            cnt      <= '0;
            kind_q   <= SETTLE_APPLY;
            seek_end <= 1'b1;
            on_cyl   <= 1'b1;
        end else if (start) begin
            busy     <= 1'b1;
            cnt      <= LOAD_VAL;
            kind_q   <= kind;
            seek_end <= 1'b0;
            on_cyl   <= 1'b0;
        end else if (busy) begin
            if (cnt == '0) begin
                busy     <= 1'b0;
                seek_end <= 1'b1;
                on_cyl   <= (kind_q == SETTLE_APPLY) || on_track;
            end else begin
                cnt <= cnt - 1'b1;
            end
        end
    end
endmodule

// File: rtl/ofs_seq_ctrl.sv
module ofs_seq_ctrl
    import ofs_seq_pkg::*;
#(
    parameter int unsigned SETTLE_CYC = 625000
) (
    input  logic clk,
    input  logic rst,
    input  logic sel,
    input  logic tag_stb,
    input  logic req_plus,
    input  logic req_minus,
    input  logic abn,
    input  logic on_track,
    output logic ofs_plus,
    output logic ofs_minus,
    output logic ofs_active,
    output logic ofs_en,
    output logic ofs_dir_out,
    output logic seek_end,
    output logic on_cyl
);
    ofs_req_e     req;
    ofs_state_t   st;
    logic         chg_pulse;
    settle_kind_e chg_kind;

    ofs_req_decode u_dec (
        .sel(sel), .tag_stb(tag_stb), .req_plus(req_plus), .req_minus(req_minus), .req(req)
    );

    ofs_state_reg u_state (
        .clk(clk), .rst(rst), .req(req), .abn(abn), .st(st)
    );

    ofs_edge_detect u_edge (
        .clk(clk), .rst(rst), .active(st.active), .pulse(chg_pulse), .kind(chg_kind)
    );

    ofs_settle_timer #(.SETTLE_CYC(SETTLE_CYC)) u_timer (
        .clk(clk), .rst(rst), .start(chg_pulse), .kind(chg_kind),
        .on_track(on_track), .seek_end(seek_end), .on_cyl(on_cyl)
    );

    assign ofs_plus    = st.plus;
    assign ofs_minus   = st.minus;
    assign ofs_active  = st.active;
    assign ofs_en      = st.active;
    assign ofs_dir_out = st.dir_out;
endmodule

// File: rtl/ofs_seq_ctrl_chk.sv
module ofs_seq_ctrl_chk (
    input logic clk,
    input logic rst,
    input logic sel,
    input logic tag_stb,
    input logic req_plus,
    input logic req_minus,
    input logic abn,
    input logic on_track,
    input logic ofs_plus,
    input logic ofs_minus,
    input logic ofs_active,
    input logic ofs_en,
    input logic ofs_dir_out,
    input logic seek_end,
    input logic on_cyl
);
    assert_plus_apply_R2: assert property (@(posedge clk) disable iff (rst)
        (tag_stb && sel && req_plus && !req_minus && !abn)
        |=> (ofs_active && ofs_en && ofs_dir_out && ofs_plus && !ofs_minus));

    assert_minus_apply_R3: assert property (@(posedge clk) disable iff (rst)
        (tag_stb && sel && req_minus && !req_plus && !abn)
        |=> (ofs_active && ofs_en && !ofs_dir_out && ofs_minus && !ofs_plus));

    assert_abn_blocks_R4: assert property (@(posedge clk) disable iff (rst)
        (tag_stb && sel && (req_plus ^ req_minus) && abn) |=> (!ofs_active && !ofs_en));

    assert_no_strobe_hold_R5: assert property (@(posedge clk) disable iff (rst)
        !(tag_stb && sel)
        |=> $stable({ofs_plus, ofs_minus, ofs_active, ofs_en, ofs_dir_out}));

    assert_conflict_hold_R6: assert property (@(posedge clk) disable iff (rst)
        (tag_stb && req_plus && req_minus)
        |=> $stable({ofs_plus, ofs_minus, ofs_active, ofs_en, ofs_dir_out}));

    assert_edge_drops_flags_R7: assert property (@(posedge clk) disable iff (rst)
        (ofs_active != $past(ofs_active)) |=> (!seek_end && !on_cyl));

    assert_clear_drops_R9: assert property (@(posedge clk) disable iff (rst)
        (tag_stb && sel && !req_plus && !req_minus)
        |=> (!ofs_active && !ofs_en && !ofs_plus && !ofs_minus && !ofs_dir_out));

    // R10: on-cylinder never comes back ahead of seek-end.
    assert_oncyl_after_end_R10: assert property (@(posedge clk) disable iff (rst)
        $rose(on_cyl) |-> seek_end);
endmodule

bind ofs_seq_ctrl ofs_seq_ctrl_chk u_chk (.*);

// File: tb/ofs_seq_ctrl_tb.sv
module ofs_seq_ctrl_tb;
    localparam int unsigned SETTLE = 16;
    localparam int NVEC = 10;
    // [7]sel [6]plus [5]minus [4]abn | expected [3]plus [2]minus [1]active [0]dir
    localparam logic [7:0] VEC [NVEC] = '{
        8'b1100_1011,  // R2 plus
        8'b1110_1011,  // R6 both bits ignored
        8'b0010_1011,  // R5 not selected
        8'b1010_0110,  // R3 minus
        8'b1000_0000,  // R9 clear
        8'b1101_1001,  // R4 plus under abn
        8'b1000_0000,  // R9 clear
        8'b1010_0110,  // R3 minus
        8'b1100_1011,  // R12 minus to plus
        8'b1000_0000   // R9 clear
    };

    logic clk = 1'b0;
    logic rst, sel, tag_stb, req_plus, req_minus, abn, on_track;
    logic ofs_plus, ofs_minus, ofs_active, ofs_en, ofs_dir_out, seek_end, on_cyl;
    int n_chk = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    ofs_seq_ctrl #(.SETTLE_CYC(SETTLE)) u_dut (
        .clk(clk), .rst(rst), .sel(sel), .tag_stb(tag_stb), .req_plus(req_plus),
        .req_minus(req_minus), .abn(abn), .on_track(on_track), .ofs_plus(ofs_plus),
        .ofs_minus(ofs_minus), .ofs_active(ofs_active), .ofs_en(ofs_en),
        .ofs_dir_out(ofs_dir_out), .seek_end(seek_end), .on_cyl(on_cyl)
    );

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%b expected=%b", tag, act, exp);
        end
    endtask

    // Drive a strobe at a falling edge; returns at the next falling edge.
    task automatic strobe(input logic s, input logic p, input logic m, input logic a);
        @(negedge clk);
        sel = s; req_plus = p; req_minus = m; abn = a; tag_stb = 1'b1;
        @(negedge clk);
        tag_stb = 1'b0; req_plus = 1'b0; req_minus = 1'b0; abn = 1'b0;
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic logic [7:0] outs();
        return {1'b0, ofs_en, seek_end, on_cyl, ofs_plus, ofs_minus, ofs_active, ofs_dir_out};
    endfunction

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk + 1 - n_fail, n_chk + 1);
        $finish;
    end

    initial begin
        rst = 1'b1; sel = 1'b0; tag_stb = 1'b0; req_plus = 1'b0; req_minus = 1'b0;
        abn = 1'b0; on_track = 1'b1;
        wait_cyc(3);
        rst = 1'b0;
        @(negedge clk);
        check("R1 reset", outs(), 8'b0011_0000);

        for (int i = 0; i < NVEC; i++) begin
            strobe(VEC[i][7], VEC[i][6], VEC[i][5], VEC[i][4]);
            check($sformatf("R2/R3/R4/R5/R6/R9/R12 vec%0d", i),
                  {4'b0, ofs_plus, ofs_minus, ofs_active, ofs_dir_out}, {4'b0, VEC[i][3:0]});
            check($sformatf("R4 enable follows active vec%0d", i),
                  {7'b0, ofs_en}, {7'b0, VEC[i][1]});
            wait_cyc(SETTLE + 3);
            check($sformatf("R8 flags settled vec%0d", i),
                  {6'b0, seek_end, on_cyl}, 8'b11);
        end

        // R7/R8: exact window on apply.
        strobe(1'b1, 1'b1, 1'b0, 1'b0);
        check("R7 flags before pulse", {6'b0, seek_end, on_cyl}, 8'b11);
        wait_cyc(1);
        check("R7 flags dropped", {6'b0, seek_end, on_cyl}, 8'b00);
        wait_cyc(SETTLE - 1);
        check("R7 flags still low at window end", {6'b0, seek_end, on_cyl}, 8'b00);
        wait_cyc(1);
        check("R8 flags restored", {6'b0, seek_end, on_cyl}, 8'b11);

        // R12: direction swap while active starts no window.
        strobe(1'b1, 1'b0, 1'b1, 1'b0);
        wait_cyc(2);
        check("R12 swap keeps flags", {6'b0, seek_end, on_cyl}, 8'b11);
        check("R12 swap to minus", {6'b0, ofs_active, ofs_dir_out}, 8'b10);

        // R11/R10: clear mid-window, head off track.
        strobe(1'b1, 1'b0, 1'b0, 1'b0);
        wait_cyc(SETTLE + 3);
        strobe(1'b1, 1'b1, 1'b0, 1'b0);
        wait_cyc(SETTLE / 2);
        on_track = 1'b0;
        strobe(1'b1, 1'b0, 1'b0, 1'b0);
        wait_cyc(SETTLE);
        check("R11 restarted window still low", {6'b0, seek_end, on_cyl}, 8'b00);
        wait_cyc(1);
        check("R10 clear off track", {6'b0, seek_end, on_cyl}, 8'b10);

        // R10: clear with head on track restores both.
        on_track = 1'b1;
        strobe(1'b1, 1'b0, 1'b1, 1'b0);
        wait_cyc(SETTLE + 3);
        strobe(1'b1, 1'b0, 1'b0, 1'b0);
        wait_cyc(SETTLE + 1);
        check("R10 clear on track", {6'b0, seek_end, on_cyl}, 8'b11);

        // R4: clear of a blocked offset has no active edge, so flags stay high.
        on_track = 1'b0;
        strobe(1'b1, 1'b1, 1'b0, 1'b1);
        wait_cyc(1);
        check("R4 blocked latch", {4'b0, ofs_plus, ofs_active, ofs_en, ofs_dir_out}, 8'b1001);
        strobe(1'b1, 1'b0, 1'b0, 1'b0);
        wait_cyc(2);
        check("R4 no window on blocked clear", {6'b0, seek_end, on_cyl}, 8'b11);

        // R1: reset in mid-offset.
        strobe(1'b1, 1'b1, 1'b0, 1'b0);
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        check("R1 reset mid offset", outs(), 8'b0011_0000);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule